// File: doc/BRIEF.md
# Look-Back Trace Channel

This block sits on a timed link between two simulator units. Every message from the producer reaches the consumer one cycle later, and nothing on the export side can slow it down. Each message is also copied into a ring memory together with the target time at which it was seen. The ring therefore holds a sliding window of recent traffic that can be examined after the fact. When the ring is full, the newest message replaces the oldest one.

The ring contents stay inside the block unless a command asks for them. A command either dumps the whole window or samples the channel's current value. Each command carries a target time and is held until target time reaches that value. A command whose time is already in the past runs at once and its response is flagged as late. Results leave through a lossless, in-order export stream with a valid/ready handshake. Every record in the stream carries a record kind, the target time, the channel identifier and a data word.

Target time is a counter inside the block that advances by one on each cycle in which `tick` is high.

Top module: `trace_chan`

## Requirements
- R1: `out_valid` and `out_data` repeat `in_valid` and `in_data` exactly one cycle later, whatever the export side or any command is doing.
- R2: After reset, `out_valid` and `exp_valid` are low, `cmd_ready` is high and target time is 0.
- R3: A dump command (`cmd_op`=0) emits one kind-0 record per retained message, from oldest to newest. Each of these records carries the message and its capture time with the late bit clear. The dump then ends with one kind-1 end record whose time field is the target time when that record is formed.
- R4: The ring keeps only the most recent DEPTH captured messages; older ones are overwritten without any record being emitted.
- R5: No record appears on the export stream unless a command has been accepted.
- R6: A value command (`cmd_op`=1) whose time lies in the future is held until target time equals that time. It then emits one kind-2 record with the late bit clear, the time equal to the command time, and the data equal to the last message passed before that cycle.
- R7: A value command whose time is already past runs at once. It emits a kind-2 record with the late bit set, the time field holding the current target time, and the last passed message as data.
- R8: While `exp_valid` is high and `exp_ready` is low, every export field holds its value and `exp_valid` stays high.
- R9: Every export record carries CHAN_ID in `exp_chan`.
- R10: Capture into the ring pauses while a dump is reading it. Messages arriving in that window still pass through, but they are not retained. Their count, saturating at MW bits, is placed in the data field of that dump's end record and then cleared.
- R11: Only one command is held at a time: `cmd_ready` drops after a command is accepted and stays low until that command starts executing.
- R12: A dump of an empty history emits only the end record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer message strobe |
| in_data | input | W | Producer message |
| out_valid | output | 1 | Consumer message strobe, registered |
| out_data | output | W | Consumer message, holds the last message |
| tick | input | 1 | Advances target time by one |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command slot free |
| cmd_op | input | 1 | 0 = dump history, 1 = sample value |
| cmd_time | input | TW | Target time at which the command runs |
| exp_valid | output | 1 | Export record valid |
| exp_ready | input | 1 | Export sink accepts record |
| exp_kind | output | 2 | 0 history entry, 1 end of dump, 2 sampled value |
| exp_late | output | 1 | Command ran after its requested time |
| exp_time | output | TW | Target time tag |
| exp_chan | output | CHW | Channel identifier |
| exp_data | output | W | Message, or missed-capture count in end records |

## Verification
The scoreboard first dumps an empty ring, then a partly filled ring, then a ring that has wrapped. Together these separate a correct oldest-first walk from an off-by-one tail or a ring that fails to overwrite. A dump under a stalling sink with traffic injected mid-dump checks two things: that history is frozen, and that the gap is counted and then cleared by the following dump. Value commands are issued once with a future time and once with a past time, which distinguishes exact scheduling from immediate execution through the late flag and the time tag.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    REC_DATA  = 2'd0,
    REC_END   = 2'd1,
    REC_VALUE = 2'd2
  } rec_kind_e;

  typedef enum logic {
    OP_DUMP = 1'b0,
    OP_PEEK = 1'b1
  } cmd_op_e;
endpackage

// File: rtl/trc_ring.sv
module trc_ring #(
  parameter int W     = 64,
  parameter int TW    = 32,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic [TW-1:0] wr_time,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic [TW-1:0] rd_time,
  output logic [AW:0]   count
);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [W+TW-1:0] mem [DEPTH];
  logic [W+TW-1:0] q;
  logic [AW-1:0]   head;
  logic [AW-1:0]   tail;
  logic [AW:0]     cnt;

  // oldest entry; equals head when the ring is full
  assign tail  = head - cnt[AW-1:0];
  assign count = cnt;

  always_ff @(posedge clk) begin
    if (wr_en) mem[head] <= {wr_time, wr_data};
  end

  always_ff @(posedge clk) begin
    if (rd_en) q <= mem[tail + rd_idx];
  end

  assign rd_time = q[W+TW-1:W];
  assign rd_data = q[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      cnt  <= '0;
    end else if (wr_en) begin
      head <= head + 1'b1;
      if (cnt != FULL) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/trc_sched.sv
module trc_sched #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_op,
  input  logic [TW-1:0] cmd_time,
  output logic          cmd_ready,
  input  logic [TW-1:0] now,
  input  logic          exp_idle,
  output logic          fire,
  output logic          fire_op,
  output logic          fire_late
);
  logic          pend;
  logic          op_q;
  logic [TW-1:0] time_q;

  assign cmd_ready = !pend;
  assign fire      = pend && exp_idle && (now >= time_q);
  assign fire_op   = op_q;
  assign fire_late = now > time_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      op_q   <= 1'b0;
      time_q <= '0;
    end else if (fire) begin
      pend <= 1'b0;
    end else if (cmd_valid && !pend) begin
      pend   <= 1'b1;
      op_q   <= cmd_op;
      time_q <= cmd_time;
    end
  end
endmodule

// File: rtl/trc_export.sv
module trc_export
  import trc_pkg::*;
#(
  parameter int W       = 64,
  parameter int TW      = 32,
  parameter int DEPTH   = 512,
  parameter int CHW     = 8,
  parameter int CHAN_ID = 0,
  parameter int MW      = 16,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fire,
  input  logic           fire_op,
  input  logic           fire_late,
  input  logic [TW-1:0]  now,
  input  logic [W-1:0]   last_data,
  input  logic           in_valid,
  input  logic [W-1:0]   rd_data,
  input  logic [TW-1:0]  rd_time,
  input  logic [AW:0]    count,
  output logic           rd_en,
  output logic [AW-1:0]  rd_idx,
  output logic           idle,
  output logic           capture_hold,
  input  logic           exp_ready,
  output logic           exp_valid,
  output logic [1:0]     exp_kind,
  output logic           exp_late,
  output logic [TW-1:0]  exp_time,
  output logic [CHW-1:0] exp_chan,
  output logic [W-1:0]   exp_data
);
  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_WT, S_SEND, S_MKLD, S_MARK, S_PEEK
  } st_e;

  st_e         st;
  logic [AW:0] idx;
  logic [AW:0] n;
  logic        late_q;
  logic [MW-1:0] miss;

  assign idle         = (st == S_IDLE);
  assign rd_en        = (st == S_RD);
  assign rd_idx       = idx[AW-1:0];
  assign capture_hold = (st == S_RD) || (st == S_WT) || (st == S_SEND) ||
                        (fire && fire_op == OP_DUMP);
  assign exp_chan     = CHW'(CHAN_ID);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      idx       <= '0;
      n         <= '0;
      late_q    <= 1'b0;
      miss      <= '0;
      exp_valid <= 1'b0;
      exp_kind  <= REC_DATA;
      exp_late  <= 1'b0;
      exp_time  <= '0;
      exp_data  <= '0;
    end else begin
      if (capture_hold && in_valid && (miss != {MW{1'b1}})) miss <= miss + 1'b1;
      case (st)
        S_IDLE: if (fire) begin
          if (fire_op == OP_DUMP) begin
            n      <= count;
            idx    <= '0;
            late_q <= fire_late;
            st     <= (count == '0) ? S_MKLD : S_RD;
          end else begin
            exp_valid <= 1'b1;
            exp_kind  <= REC_VALUE;
            exp_late  <= fire_late;
            exp_time  <= now;
            exp_data  <= last_data;
            st        <= S_PEEK;
          end
        end
        S_RD: st <= S_WT;
        S_WT: begin
          exp_valid <= 1'b1;
          exp_kind  <= REC_DATA;
          exp_late  <= 1'b0;
          exp_time  <= rd_time;
          exp_data  <= rd_data;
          st        <= S_SEND;
        end
        S_SEND: if (exp_ready) begin
          exp_valid <= 1'b0;
          if (idx + (AW+1)'(1) == n) st <= S_MKLD;
          else begin
            idx <= idx + (AW+1)'(1);
            st  <= S_RD;
          end
        end
        S_MKLD: begin
          exp_valid <= 1'b1;
          exp_kind  <= REC_END;
          exp_late  <= late_q;
          exp_time  <= now;
          exp_data  <= W'(miss);
          st        <= S_MARK;
        end
        S_MARK: if (exp_ready) begin
          exp_valid <= 1'b0;
          miss      <= '0;
          st        <= S_IDLE;
        end
        S_PEEK: if (exp_ready) begin
          exp_valid <= 1'b0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trace_chan.sv
module trace_chan #(
  parameter int W       = 64,
  parameter int TW      = 32,
  parameter int DEPTH   = 512,
  parameter int CHW     = 8,
  parameter int CHAN_ID = 0,
  parameter int MW      = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   in_data,
  output logic           out_valid,
  output logic [W-1:0]   out_data,
  input  logic           tick,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic           cmd_op,
  input  logic [TW-1:0]  cmd_time,
  output logic           exp_valid,
  input  logic           exp_ready,
  output logic [1:0]     exp_kind,
  output logic           exp_late,
  output logic [TW-1:0]  exp_time,
  output logic [CHW-1:0] exp_chan,
  output logic [W-1:0]   exp_data
);
  localparam int AW = $clog2(DEPTH);

  logic [TW-1:0] now;
  logic          hold;
  logic          fire, fire_op, fire_late, exp_idle;
  logic          rd_en;
  logic [AW-1:0] rd_idx;
  logic [W-1:0]  rd_data;
  logic [TW-1:0] rd_time;
  logic [AW:0]   count;

  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else if (tick) now <= now + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  trc_ring #(.W(W), .TW(TW), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst(rst),
    .wr_en(in_valid && !hold), .wr_data(in_data), .wr_time(now),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_time(rd_time), .count(count)
  );

  trc_sched #(.TW(TW)) u_sched (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_time(cmd_time),
    .cmd_ready(cmd_ready), .now(now), .exp_idle(exp_idle),
    .fire(fire), .fire_op(fire_op), .fire_late(fire_late)
  );

  trc_export #(.W(W), .TW(TW), .DEPTH(DEPTH), .CHW(CHW),
               .CHAN_ID(CHAN_ID), .MW(MW)) u_exp (
    .clk(clk), .rst(rst),
    .fire(fire), .fire_op(fire_op), .fire_late(fire_late),
    .now(now), .last_data(out_data), .in_valid(in_valid),
    .rd_data(rd_data), .rd_time(rd_time), .count(count),
    .rd_en(rd_en), .rd_idx(rd_idx), .idle(exp_idle), .capture_hold(hold),
    .exp_ready(exp_ready), .exp_valid(exp_valid), .exp_kind(exp_kind),
    .exp_late(exp_late), .exp_time(exp_time), .exp_chan(exp_chan),
    .exp_data(exp_data)
  );
endmodule

// File: rtl/trace_chan_chk.sv
module trace_chan_chk #(
  parameter int W  = 64,
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [W-1:0]  in_data,
  input logic          out_valid,
  input logic [W-1:0]  out_data,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          exp_valid,
  input logic          exp_ready,
  input logic [1:0]    exp_kind,
  input logic          exp_late,
  input logic [TW-1:0] exp_time,
  input logic [W-1:0]  exp_data
);
  logic cmd_seen;

  always_ff @(posedge clk) begin
    if (rst) cmd_seen <= 1'b0;
    else if (cmd_valid && cmd_ready) cmd_seen <= 1'b1;
  end

  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid && out_data == $past(in_data));

  // R2
  reset_state_chk: assert property (@(posedge clk)
    $fell(rst) |-> !exp_valid && !out_valid && cmd_ready);

  // R5
  no_unasked_export_chk: assert property (@(posedge clk) disable iff (rst)
    exp_valid |-> cmd_seen);

  // R8
  export_hold_chk: assert property (@(posedge clk) disable iff (rst)
    exp_valid && !exp_ready |=> exp_valid && $stable(exp_data) &&
      $stable(exp_time) && $stable(exp_kind) && $stable(exp_late));

  // R11
  single_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> !cmd_ready);
endmodule

bind trace_chan trace_chan_chk #(.W(W), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .exp_valid(exp_valid), .exp_ready(exp_ready), .exp_kind(exp_kind),
  .exp_late(exp_late), .exp_time(exp_time), .exp_data(exp_data)
);

// File: tb/tb_trace_chan.sv
`timescale 1ns/1ps
module tb_trace_chan;
  localparam int W = 16, TW = 16, DEPTH = 8, CHW = 8, CHAN = 5, MW = 8;
  localparam int RW = 2 + 1 + TW + CHW + W;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic [W-1:0] in_data = '0;
  logic out_valid;
  logic [W-1:0] out_data;
  logic tick = 0;
  logic cmd_valid = 0;
  logic cmd_ready;
  logic cmd_op = 0;
  logic [TW-1:0] cmd_time = '0;
  logic exp_valid;
  logic exp_ready = 0;
  logic [1:0] exp_kind;
  logic exp_late;
  logic [TW-1:0] exp_time;
  logic [CHW-1:0] exp_chan;
  logic [W-1:0] exp_data;

  always #4 clk = ~clk;

  trace_chan #(.W(W), .TW(TW), .DEPTH(DEPTH), .CHW(CHW), .CHAN_ID(CHAN), .MW(MW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .tick(tick),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_time(cmd_time),
    .exp_valid(exp_valid), .exp_ready(exp_ready), .exp_kind(exp_kind),
    .exp_late(exp_late), .exp_time(exp_time), .exp_chan(exp_chan), .exp_data(exp_data)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rdy_mode = 1;
  bit capture_on = 1;
  logic [TW-1:0] now_m = '0;
  logic [W-1:0] last_m = '0;
  logic [TW+W-1:0] hist[$];
  logic [RW-1:0] exp_q[$];
  string tag_q[$];

  function automatic logic [RW-1:0] rec(input logic [1:0] k, input logic l,
                                        input logic [TW-1:0] t, input logic [W-1:0] d);
    return {k, l, t, CHW'(CHAN), d};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // ready driver
  always @(negedge clk) begin
    cyc++;
    exp_ready <= (rdy_mode == 0) ? 1'b0 : (rdy_mode == 1) ? 1'b1 : ((cyc % 3) != 0);
  end

  // monitor: scoreboard compare on each handshake (R3 R6 R7 R9)
  initial begin
    forever begin
      @(negedge clk); #2;
      if (!rst && exp_valid && exp_ready) begin
        logic [RW-1:0] got;
        got = {exp_kind, exp_late, exp_time, exp_chan, exp_data};
        if (exp_q.size() == 0) begin
          check(0, "R5 unexpected record", 64'(got), 64'(0));
        end else begin
          logic [RW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got == e, t, 64'(got), 64'(e));
        end
      end
    end
  end

  task automatic expect_rec(input logic [RW-1:0] r, input string t);
    exp_q.push_back(r);
    tag_q.push_back(t);
  endtask

  task automatic send(input logic [W-1:0] d);
    @(negedge clk);
    in_valid = 1; in_data = d;
    @(negedge clk);
    in_valid = 0;
    // R1
    check(out_valid && out_data == d, "R1 pass-through", 64'(out_data), 64'(d));
    last_m = d;
    if (capture_on) begin
      hist.push_back({now_m, d});
      if (hist.size() > DEPTH) void'(hist.pop_front());
    end
  endtask

  task automatic advance(input int n);
    repeat (n) begin @(negedge clk); tick = 1; end
    @(negedge clk); tick = 0;
    now_m += TW'(n);
  endtask

  task automatic issue(input logic op, input logic [TW-1:0] t);
    @(negedge clk);
    check(cmd_ready, "R11 slot free before command", 64'(cmd_ready), 64'(1));
    cmd_valid = 1; cmd_op = op; cmd_time = t;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic expect_dump(input logic [W-1:0] miss, input string t);
    foreach (hist[i]) expect_rec(rec(2'd0, 1'b0, hist[i][TW+W-1:W], hist[i][W-1:0]), t);
    expect_rec(rec(2'd1, 1'b0, now_m, miss), {t, " end record"});
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000 / 2) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R2
    check(!exp_valid && !out_valid && cmd_ready, "R2 reset state",
          64'({exp_valid, out_valid, cmd_ready}), 64'(3'b001));

    // R12 empty history
    expect_dump('0, "R12 empty dump");
    issue(1'b0, now_m);
    drain();

    // R5 traffic without command exports nothing
    for (int i = 0; i < 3; i++) begin
      send(16'h1000 + 16'(i));
      advance(2);
    end
    repeat (6) @(negedge clk);
    check(!exp_valid && exp_q.size() == 0, "R5 no export without command", 64'(exp_valid), 64'(0));

    // R3 oldest-first dump
    expect_dump('0, "R3 dump order");
    issue(1'b0, now_m);
    drain();

    // R4 wrap, with sink backpressure (R8)
    rdy_mode = 2;
    for (int i = 0; i < 10; i++) begin
      send(16'h2000 + 16'(i));
      advance(1);
    end
    expect_dump('0, "R4 wrapped window");
    issue(1'b0, now_m);
    drain();
    rdy_mode = 1;

    // R10 capture paused during dump
    rdy_mode = 0;
    expect_dump(16'd2, "R10 dump with gap");
    issue(1'b0, now_m);
    do begin @(negedge clk); #2; end while (!exp_valid);
    capture_on = 0;
    send(16'h3001);
    send(16'h3002);
    capture_on = 1;
    rdy_mode = 1;
    drain();
    expect_dump('0, "R10 gap cleared and not retained");
    issue(1'b0, now_m);
    drain();

    // R6 future value command
    advance(3);
    begin
      logic [TW-1:0] t;
      t = now_m + 16'd4;
      expect_rec(rec(2'd2, 1'b0, t, last_m), "R6 timed value");
      issue(1'b1, t);
      // R11
      check(!cmd_ready, "R11 slot held while pending", 64'(cmd_ready), 64'(0));
      advance(8);
      drain();
    end

    // R7 late value command
    expect_rec(rec(2'd2, 1'b1, now_m, last_m), "R7 late value");
    issue(1'b1, now_m - 16'd2);
    drain();

    finish_run();
  end
endmodule